// File: doc/BRIEF.md
# Host Interrupt Status Collector

This block gathers interrupt events from several neighbours into one 16-bit sticky status word. It drives a single active-low interrupt line toward the host, asserted while any status bit is set. Bus-error, codec-wakeup and mailbox events latch on the rising edge of their source. The GPIO bit instead follows the OR of a bank of per-pin sticky GPIO flags, which the block also holds.

The host reads the word and clears bits by writing ones. If the host clears the GPIO bit while a per-pin GPIO flag is still set, the bit and the interrupt line come back one cycle later. A GPIO event that arrives while an interrupt service routine is acknowledging another one is therefore never lost. Unused positions read as zero.

Top module: `host_irq_collector`

## Requirements
- R1: After reset, the status word reads 0, every per-pin GPIO flag is 0 and `irq_n` is 1.
- R2: Bit positions: 14 target abort, 13 master abort, 12 codec-link wakeup, 8/7 outgoing mailbox 1/0, 6/5 incoming mailbox 1/0. Each latches to 1 on the clock edge at which its source is first sampled high after having been sampled low.
- R3: Writing (`reg_wr`=1) clears each status bit whose `reg_wdata` bit is 1. Bits written with 0 keep their value.
- R4: If a rising edge and a write-one-to-clear hit the same edge-latched bit in the same cycle, the bit stays set.
- R5: A per-pin GPIO flag is set on any cycle in which its `gpio_evt` bit is 1. It is cleared by a 1 on its `gpio_clr` bit, with the event winning over the clear. The flags are visible on `gpio_status`.
- R6: Bit 11 becomes 1 on the edge after any GPIO flag is seen set. It is sticky until written with 1.
- R7: Writing 1 to bit 11 makes it read 0 on the next cycle. If any GPIO flag is still set, the bit reads 1 again one cycle after that.
- R8: Bits 15, 10, 9 and 4..0 always read 0, whatever is written.
- R9: `irq_n` is registered and equals the inverse of the OR of the status word, in step with `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tgt_abort | input | 1 | Target abort detected |
| src_mst_abort | input | 1 | Master abort detected |
| src_codec_wake | input | 1 | Codec-link wakeup |
| src_mbox_out | input | 2 | Outgoing mailbox transfer flags (index = mailbox) |
| src_mbox_in | input | 2 | Incoming mailbox transfer flags (index = mailbox) |
| gpio_evt | input | GPIO_PINS | Per-pin GPIO event |
| gpio_clr | input | GPIO_PINS | Per-pin GPIO flag clear |
| gpio_status | output | GPIO_PINS | Per-pin GPIO sticky flags |
| reg_wr | input | 1 | Host write strobe |
| reg_wdata | input | 16 | Host write data, ones clear |
| reg_rdata | output | 16 | Status word |
| irq_n | output | 1 | Active-low interrupt line |

## Verification
The assertions assume that each source holds a level for at least one cycle, so that a rising edge means a low sample followed by a high one. They also assume that a write lasts a single cycle, with write data that means something only while `reg_wr` is high. The random stimulus drives sources as slowly changing levels, which gives spaced rising edges, and it pulses writes with random masks. Directed cases line up an event with a clear, clear bit 11 with GPIO flags pending, and write to reserved positions.

// File: rtl/host_irq_collector.sv
module host_irq_collector #(
  parameter int GPIO_PINS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 src_tgt_abort,
  input  logic                 src_mst_abort,
  input  logic                 src_codec_wake,
  input  logic [1:0]           src_mbox_out,
  input  logic [1:0]           src_mbox_in,
  input  logic [GPIO_PINS-1:0] gpio_evt,
  input  logic [GPIO_PINS-1:0] gpio_clr,
  output logic [GPIO_PINS-1:0] gpio_status,
  input  logic                 reg_wr,
  input  logic [15:0]          reg_wdata,
  output logic [15:0]          reg_rdata,
  output logic                 irq_n
);
  localparam int          LVL_BIT   = 11;
  localparam logic [15:0] EDGE_MASK = 16'h71E0;

  logic [15:0]          src_vec, src_q, clr_vec, sts_q, sts_d;
  logic [GPIO_PINS-1:0] gpio_d;
  logic                 lvl_d;

  assign src_vec = {1'b0, src_tgt_abort, src_mst_abort, src_codec_wake, 3'b000,
                    src_mbox_out[1], src_mbox_out[0], src_mbox_in[1], src_mbox_in[0], 5'b00000};
  assign clr_vec = reg_wr ? reg_wdata : 16'h0000;
  assign gpio_d  = gpio_evt | (gpio_status & ~gpio_clr);
  assign lvl_d   = clr_vec[LVL_BIT] ? 1'b0 : (sts_q[LVL_BIT] | (|gpio_status));

  always_comb begin
    sts_d          = EDGE_MASK & ((src_vec & ~src_q) | (sts_q & ~clr_vec));
    sts_d[LVL_BIT] = lvl_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q       <= '0;
      sts_q       <= '0;
      gpio_status <= '0;
      irq_n       <= 1'b1;
    end else begin
      src_q       <= src_vec;
      sts_q       <= sts_d;
      gpio_status <= gpio_d;
      irq_n       <= ~(|sts_d);
    end
  end

  assign reg_rdata = sts_q;
endmodule

// File: rtl/host_irq_collector_chk.sv
module host_irq_collector_chk #(
  parameter int GPIO_PINS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 src_tgt_abort,
  input logic [GPIO_PINS-1:0] gpio_evt,
  input logic [GPIO_PINS-1:0] gpio_status,
  input logic                 reg_wr,
  input logic [15:0]          reg_wdata,
  input logic [15:0]          reg_rdata,
  input logic                 irq_n
);
  logic [15:0] clr_seen;
  assign clr_seen = reg_wr ? reg_wdata : 16'h0000;

  a_r9_pin_follows_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == ~(|reg_rdata));

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & 16'b1000_0110_0001_1111) == 16'h0000);

  a_r3_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(reg_rdata) & ~$past(clr_seen)) & ~reg_rdata) == 16'h0000));

  a_r2_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_tgt_abort) |=> reg_rdata[14]);

  a_r5_gpio_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|gpio_evt) |=> ((gpio_status & $past(gpio_evt)) == $past(gpio_evt)));

  a_r7_level_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[11]) |=> !reg_rdata[11]);

  a_r6_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gpio_status) && !(reg_wr && reg_wdata[11])) |=> reg_rdata[11]);
endmodule

bind host_irq_collector host_irq_collector_chk #(.GPIO_PINS(GPIO_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_tgt_abort(src_tgt_abort), .gpio_evt(gpio_evt),
  .gpio_status(gpio_status), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .irq_n(irq_n));

// File: tb/host_irq_collector_bench.sv
module host_irq_collector_bench;
  localparam int N = 8;
  localparam logic [15:0] EMASK = 16'h71E0;

  logic clk = 0, rst_n = 0;
  logic tab = 0, mab = 0, cwk = 0, reg_wr = 0, irq_n;
  logic [1:0] mo = 0, mi = 0;
  logic [N-1:0] gevt = 0, gclr = 0, gsts;
  logic [15:0] wd = 0, rdata;

  int checks = 0, fails = 0;
  logic [15:0] m_src = 0, m_sts = 0;
  logic [N-1:0] m_g = 0;
  logic m_irq = 1;

  always #2 clk = ~clk;

  host_irq_collector #(.GPIO_PINS(N)) u_host_irq_collector (
    .clk(clk), .rst_n(rst_n), .src_tgt_abort(tab), .src_mst_abort(mab),
    .src_codec_wake(cwk), .src_mbox_out(mo), .src_mbox_in(mi), .gpio_evt(gevt),
    .gpio_clr(gclr), .gpio_status(gsts), .reg_wr(reg_wr), .reg_wdata(wd),
    .reg_rdata(rdata), .irq_n(irq_n));

  function automatic logic [15:0] pack_src();
    logic [15:0] v = 0;
    v[14] = tab; v[13] = mab; v[12] = cwk;
    v[8] = mo[1]; v[7] = mo[0]; v[6] = mi[1]; v[5] = mi[0];
    return v;
  endfunction

  function automatic logic [15:0] next_sts(logic [15:0] s, logic [15:0] sq,
      logic [15:0] src, logic [15:0] clr, logic any_g);
    logic [15:0] n = ((src & ~sq) | (s & ~clr)) & EMASK;
    n[11] = clr[11] ? 1'b0 : (s[11] | any_g);
    return n;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    logic [15:0] clr, src;
    @(posedge clk);
    src = pack_src();
    clr = reg_wr ? wd : 16'h0;
    m_sts = next_sts(m_sts, m_src, src, clr, |m_g);
    m_g = gevt | (m_g & ~gclr);
    m_src = src;
    m_irq = ~(|m_sts);
    @(negedge clk);
    chk("R2 R3 status", rdata, m_sts);
    chk("R5 gpio flags", gsts, m_g);
    chk("R9 irq pin", irq_n, m_irq);
  endtask

  task automatic idle();
    reg_wr = 0; wd = 0; gevt = 0; gclr = 0;
  endtask

  initial begin
    int unsigned seed = $urandom(32'd1729);
    if (seed == 0) idle();
    repeat (3) @(negedge clk);
    chk("R1 reset status", rdata, 16'h0);
    chk("R1 reset gpio", gsts, '0);
    chk("R1 reset pin", irq_n, 1'b1);
    rst_n = 1;

    // R2: edge latch on target abort
    tab = 1; step(); chk("R2 target abort bit14", rdata[14], 1'b1);
    chk("R9 pin low", irq_n, 1'b0);
    // R3: write zero keeps, write one clears
    reg_wr = 1; wd = 16'h0000; step(); chk("R3 write zero keeps", rdata[14], 1'b1);
    wd = 16'h4000; step(); idle(); chk("R3 w1c clears", rdata[14], 1'b0);
    step(); chk("R2 held level no relatch", rdata[14], 1'b0);
    tab = 0; step();
    // R4: edge and clear in same cycle
    mi[0] = 1; reg_wr = 1; wd = 16'hFFFF; step(); idle();
    chk("R4 edge beats clear", rdata[5], 1'b1);
    mi[0] = 0; reg_wr = 1; wd = 16'h0020; step(); idle();
    // R8: reserved bits
    reg_wr = 1; wd = 16'h861F; step(); idle();
    chk("R8 reserved read zero", rdata & 16'h861F, 16'h0);
    // R6/R7: level reassert
    gevt = 8'h04; step(); gevt = 0; step();
    chk("R6 level bit set", rdata[11], 1'b1);
    reg_wr = 1; wd = 16'h0800; step(); idle();
    chk("R7 cleared one cycle", rdata[11], 1'b0);
    step(); chk("R7 reasserts", rdata[11], 1'b1);
    gclr = 8'h04; step(); gclr = 0;
    reg_wr = 1; wd = 16'h0800; step(); idle(); step();
    chk("R7 stays clear when no gpio", rdata[11], 1'b0);
    chk("R9 pin released", irq_n, 1'b1);
    // R5: event beats per-pin clear
    gevt = 8'h81; gclr = 8'h81; step(); idle();
    chk("R5 event beats clear", gsts, 8'h81);
    gclr = 8'hFF; step(); idle();

    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 6 == 0) tab = ~tab;
      if ($urandom % 6 == 0) mab = ~mab;
      if ($urandom % 7 == 0) cwk = ~cwk;
      if ($urandom % 5 == 0) mo = 2'($urandom);
      if ($urandom % 5 == 0) mi = 2'($urandom);
      gevt = ($urandom % 8 == 0) ? N'($urandom) & N'($urandom) : '0;
      gclr = ($urandom % 4 == 0) ? N'($urandom) : '0;
      reg_wr = ($urandom % 3 == 0);
      wd = 16'($urandom);
      step();
    end
    idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule